// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the memory-mapped state store of an interrupt distributor. It serves a few CPUs (four by default) and a parameterised number of interrupt lines (128 by default). Software reaches it over a simple request/response bus with a 12-bit byte address. Each access moves one byte, one halfword or one word. The requesting CPU's index travels with every request.

For every line the block keeps several kinds of state:
- an enable bit and a pending bit, each written through separate set and clear aliases;
- a priority byte;
- a target CPU;
- an edge/level flag.

Lines 0 to 31 are private, with a separate copy per CPU. The copy used is selected by the requester's index. Lines 32 and up are shared.

The block drives one flag per CPU. A CPU's flag is high when the global enable is on and at least one line is pending, enabled and aimed at that CPU. Priority arbitration and the CPU-side interfaces sit downstream and use these flags.

Top module: `distr_regbank`

## Requirements
- R1: `req_ready` is always high. Every request with `req_valid` high gets `rsp_valid` high in the next cycle, and in no other cycle. Read data appears in `rsp_rdata`; writes return zero.
- R2: Access size uses `req_size`: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes.
  - Read data is the addressed word shifted right by 8×`req_addr[1:0]` and masked to the access length.
  - Write data is taken from the low bytes of `req_wdata` and placed at that byte offset.
  - Only the covered byte lanes are written.
- R3: `req_size` = 3 (8 bytes) returns `rsp_err` = 1 with zero data and changes no state. Every other access returns `rsp_err` = 0.
- R4: There are three fixed registers.
  - Word 0x000: bit 0 is the global enable (reset 0).
  - Word 0x004: reads ((NUM_CPU−1) << 5) | (NUM_IRQ/32 − 1), which is 0x63 by default.
  - Word 0x008: reads 0x4B00043B.
  - Writes to 0x004 and 0x008 are ignored.
- R5: Enable bits use one bit per line: line 32n+b sits at bit b of word n. The set alias is at 0x100 and the clear alias at 0x180. Writing 1 sets (or clears) a bit, writing 0 leaves it unchanged, and both aliases read the enable state. Out of reset, lines 0–15 are enabled and all others are disabled.
- R6: Enable bits of lines 0–15 cannot be cleared. They read as 1 after any clear.
- R7: Pending bits use the same one-bit-per-line layout, with the set alias at 0x200 and the clear alias at 0x280. All pending bits reset to 0.
- R8: Lines 0–31 are private per CPU in the enable, pending, priority and configuration regions. Each access uses the copy of the CPU given on `req_cpu`.
- R9: The priority of line n is the read/write byte at 0x400+n. Reset value is 0.
- R10: The target of line n ≥ 32 is the byte at 0x800+n.
  - A write keeps only the lowest set bit among bits [NUM_CPU−1:0] of the byte.
  - A byte with none of those bits set selects CPU 0.
  - The byte reads back as the one-hot code of the selected CPU.
  - Reset target is CPU 0.
- R11: Target bytes of lines 0–31 are read-only. Each reads as the requester's one-hot code in all four bytes.
- R12: Configuration words start at 0xC00. Word w covers lines 16w to 16w+15.
  - The edge flag of line 16w+k is bit 2k+1; even bits read 0.
  - Word 0 ignores writes and reads 0xAAAAAAAA.
  - Out of reset, lines 0–31 are edge-triggered and the others are level-triggered.
- R13: The following read zero and ignore writes:
  - the group region 0x080;
  - the active regions 0x300 and 0x380;
  - unused addresses.
- R14: `irq_pend[c]` = global enable AND (some private line of CPU c is pending and enabled, OR some shared line is pending, enabled and targeted at c). The flag reflects a write in the cycle after the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always high; a request is taken in the cycle it is valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CPU_W | Index of the requesting CPU |
| req_addr | input | 12 | Byte address |
| req_size | input | 2 | log2 of the access length in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_err | output | 1 | Access-size error |
| rsp_rdata | output | 32 | Read data, right-aligned |
| irq_pend | output | NUM_CPU | Per-CPU pending flag |

## Verification
The pending flags are driven through three patterns:
- a private line raised by one CPU, first with the global enable off and then on, which separates gating by the enable from the per-CPU private copy;
- a shared line steered by target bytes of mixed patterns, which shows the lowest-bit reduction and the all-zero fallback;
- a single-byte retarget of that line, which moves the flag to another CPU while leaving the neighbouring target bytes untouched.

Byte and halfword accesses at non-zero offsets in the priority and configuration regions separate correct lane masking from whole-word replacement. A doubleword write to a pending alias shows that an error response leaves the state unchanged.

// File: rtl/distr_pkg.sv
package distr_pkg;

  typedef enum logic [3:0] {
    RG_ZERO,
    RG_CTRL,
    RG_TYPE,
    RG_IDENT,
    RG_SETEN,
    RG_CLREN,
    RG_SETPD,
    RG_CLRPD,
    RG_PRIO,
    RG_TGT,
    RG_CFG
  } region_e;

  localparam logic [31:0] IDENT_VALUE  = 32'h4B00043B;
  localparam logic [1:0]  SIZE_DWORD   = 2'd3;
  localparam logic [31:0] CFG_LOCKED   = 32'hAAAAAAAA;

endpackage

// File: rtl/distr_decode.sv
module distr_decode
  import distr_pkg::*;
#(
  parameter int NUM_IRQ = 128
) (
  input  logic [11:0] addr,
  input  logic [1:0]  size,
  input  logic [31:0] wdata,
  output region_e     region,
  output logic [7:0]  word,
  output logic [31:0] wbits,
  output logic [31:0] lane_bits,
  output logic [3:0]  lanes,
  output logic [4:0]  shift,
  output logic [31:0] len_mask,
  output logic        err
);
  localparam int BIT_WORDS  = NUM_IRQ / 32;
  localparam int BYTE_WORDS = NUM_IRQ / 4;
  localparam int CFG_WORDS  = NUM_IRQ / 16;

  logic in_bits, in_bytes, in_cfg;

  always_comb begin
    unique case (size)
      2'd0:    len_mask = 32'h0000_00FF;
      2'd1:    len_mask = 32'h0000_FFFF;
      default: len_mask = 32'hFFFF_FFFF;
    endcase
    shift     = {addr[1:0], 3'b000};
    lane_bits = len_mask << shift;
    wbits     = (wdata & len_mask) << shift;
    for (int l = 0; l < 4; l++) lanes[l] = lane_bits[8*l];
    err       = (size == SIZE_DWORD);
  end

  always_comb begin
    in_bits  = {27'd0, addr[6:2]} < BIT_WORDS;
    in_bytes = {24'd0, addr[9:2]} < BYTE_WORDS;
    in_cfg   = {24'd0, addr[9:2]} < CFG_WORDS;
    word     = (addr[11:10] == 2'b00) ? {3'd0, addr[6:2]} : addr[9:2];
    region   = RG_ZERO;
    unique case (addr[11:10])
      2'b00: begin
        unique case (addr[9:7])
          3'd0: begin
            unique case (addr[6:2])
              5'd0:    region = RG_CTRL;
              5'd1:    region = RG_TYPE;
              5'd2:    region = RG_IDENT;
              default: region = RG_ZERO;
            endcase
          end
          3'd2:    if (in_bits) region = RG_SETEN;
          3'd3:    if (in_bits) region = RG_CLREN;
          3'd4:    if (in_bits) region = RG_SETPD;
          3'd5:    if (in_bits) region = RG_CLRPD;
          default: region = RG_ZERO;
        endcase
      end
      2'b01:   if (in_bytes) region = RG_PRIO;
      2'b10:   if (in_bytes) region = RG_TGT;
      default: if (in_cfg)   region = RG_CFG;
    endcase
  end

endmodule

// File: rtl/distr_bitvec.sv
module distr_bitvec #(
  parameter int          NUM_CPU    = 4,
  parameter int          NUM_IRQ    = 128,
  parameter logic [31:0] LOCK_ONES  = 32'h0,
  parameter logic [31:0] RESET_BANK = 32'h0,
  localparam int         CPU_W      = $clog2(NUM_CPU),
  localparam int         SH         = NUM_IRQ - 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       set_en,
  input  logic                       clr_en,
  input  logic [CPU_W-1:0]           cpu,
  input  logic [7:0]                 word,
  input  logic [31:0]                bits,
  output logic [31:0]                rd_word,
  output logic [NUM_CPU-1:0][31:0]   bank_o,
  output logic [SH-1:0]              shared_o
);
  localparam int WORDS = NUM_IRQ / 32;

  logic [NUM_CPU-1:0][31:0] bank_q, bank_d;
  logic [SH-1:0]            sh_q, sh_d;
  logic                     upd;

  assign upd = set_en | clr_en;

  always_comb begin
    bank_d = bank_q;
    sh_d   = sh_q;
    if (word == 8'd0) begin
      bank_d[cpu] = (set_en ? (bank_q[cpu] | bits) : (bank_q[cpu] & ~bits)) | LOCK_ONES;
    end else begin
      for (int w = 1; w < WORDS; w++) begin
        if (word == 8'(w))
          sh_d[(w-1)*32 +: 32] = set_en ? (sh_q[(w-1)*32 +: 32] | bits)
                                        : (sh_q[(w-1)*32 +: 32] & ~bits);
      end
    end
  end

  always_comb begin
    rd_word = bank_q[cpu];
    for (int w = 1; w < WORDS; w++) begin
      if (word == 8'(w)) rd_word = sh_q[(w-1)*32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= {NUM_CPU{RESET_BANK}};
      sh_q   <= '0;
    end else if (upd) begin
      bank_q <= bank_d;
      sh_q   <= sh_d;
    end
  end

  assign bank_o   = bank_q;
  assign shared_o = sh_q;

endmodule

// File: rtl/distr_pendcalc.sv
module distr_pendcalc #(
  parameter int  NUM_CPU = 4,
  parameter int  NUM_IRQ = 128,
  localparam int CPU_W   = $clog2(NUM_CPU),
  localparam int SH      = NUM_IRQ - 32
) (
  input  logic                           glb_en,
  input  logic [NUM_CPU-1:0][31:0]       en_bank,
  input  logic [NUM_CPU-1:0][31:0]       pd_bank,
  input  logic [SH-1:0]                  en_sh,
  input  logic [SH-1:0]                  pd_sh,
  input  logic [SH-1:0][CPU_W-1:0]       tgt,
  output logic [NUM_CPU-1:0]             pend
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [SH-1:0] hit;
    for (genvar i = 0; i < SH; i++) begin : g_line
      assign hit[i] = en_sh[i] & pd_sh[i] & (tgt[i] == CPU_W'(c));
    end
    assign pend[c] = glb_en & ((|(en_bank[c] & pd_bank[c])) | (|hit));
  end

endmodule

// File: rtl/distr_regbank.sv
module distr_regbank
  import distr_pkg::*;
#(
  parameter int  NUM_CPU = 4,
  parameter int  NUM_IRQ = 128,
  localparam int CPU_W   = $clog2(NUM_CPU)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [CPU_W-1:0]   req_cpu,
  input  logic [11:0]        req_addr,
  input  logic [1:0]         req_size,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [31:0]        rsp_rdata,
  output logic [NUM_CPU-1:0] irq_pend
);
  localparam int SH   = NUM_IRQ - 32;
  localparam int SH_W = $clog2(SH);
  localparam logic [31:0] TYPE_VALUE = 32'(((NUM_CPU - 1) << 5) | (NUM_IRQ / 32 - 1));

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  region_e     region;
  logic [7:0]  word;
  logic [31:0] wbits, lane_bits, len_mask;
  logic [3:0]  lanes;
  logic [4:0]  shift;
  logic        err;

  distr_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (
    .addr(req_addr), .size(req_size), .wdata(req_wdata),
    .region(region), .word(word), .wbits(wbits), .lane_bits(lane_bits),
    .lanes(lanes), .shift(shift), .len_mask(len_mask), .err(err)
  );

  logic wr;
  assign wr        = req_valid & req_write & ~err;
  assign req_ready = 1'b1;

  // enable and pending bit arrays
  logic [31:0]              en_rd, pd_rd;
  logic [NUM_CPU-1:0][31:0] en_bank, pd_bank;
  logic [SH-1:0]            en_sh, pd_sh;

  distr_bitvec #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ),
                 .LOCK_ONES(32'h0000FFFF), .RESET_BANK(32'h0000FFFF)) u_en (
    .clk(clk), .rst_n(rst_int_n),
    .set_en(wr && region == RG_SETEN), .clr_en(wr && region == RG_CLREN),
    .cpu(req_cpu), .word(word), .bits(wbits),
    .rd_word(en_rd), .bank_o(en_bank), .shared_o(en_sh)
  );

  distr_bitvec #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ),
                 .LOCK_ONES(32'h0), .RESET_BANK(32'h0)) u_pd (
    .clk(clk), .rst_n(rst_int_n),
    .set_en(wr && region == RG_SETPD), .clr_en(wr && region == RG_CLRPD),
    .cpu(req_cpu), .word(word), .bits(wbits),
    .rd_word(pd_rd), .bank_o(pd_bank), .shared_o(pd_sh)
  );

  // control, priority, target, configuration state
  logic                          ctrl_q, ctrl_d;
  logic [NUM_CPU-1:0][31:0][7:0] pri_bank_q, pri_bank_d;
  logic [SH-1:0][7:0]            pri_sh_q, pri_sh_d;
  logic [SH-1:0][CPU_W-1:0]      tgt_q, tgt_d;
  logic [NUM_CPU-1:0][15:0]      cfg_bank_q, cfg_bank_d;
  logic [SH-1:0]                 cfg_sh_q, cfg_sh_d;

  function automatic logic [CPU_W-1:0] pick_cpu(input logic [7:0] b);
    pick_cpu = '0;
    for (int k = NUM_CPU - 1; k >= 0; k--) begin
      if (b[k]) pick_cpu = CPU_W'(k);
    end
  endfunction

  always_comb begin
    ctrl_d     = ctrl_q;
    pri_bank_d = pri_bank_q;
    pri_sh_d   = pri_sh_q;
    tgt_d      = tgt_q;
    cfg_bank_d = cfg_bank_q;
    cfg_sh_d   = cfg_sh_q;
    if (wr && region == RG_CTRL && lanes[0]) ctrl_d = wbits[0];
    for (int l = 0; l < 4; l++) begin
      if (wr && lanes[l]) begin
        if (region == RG_PRIO) begin
          if (int'(word) * 4 + l < 32) pri_bank_d[req_cpu][5'(int'(word) * 4 + l)] = wbits[8*l +: 8];
          else pri_sh_d[SH_W'(int'(word) * 4 + l - 32)] = wbits[8*l +: 8];
        end
        if (region == RG_TGT && int'(word) * 4 + l >= 32)
          tgt_d[SH_W'(int'(word) * 4 + l - 32)] = pick_cpu(wbits[8*l +: 8]);
      end
    end
    if (wr && region == RG_CFG) begin
      for (int k = 0; k < 16; k++) begin
        if (lane_bits[2*k+1]) begin
          if (word == 8'd1) cfg_bank_d[req_cpu][k] = wbits[2*k+1];
          else if (word >= 8'd2) cfg_sh_d[SH_W'((int'(word) - 2) * 16 + k)] = wbits[2*k+1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q     <= 1'b0;
      pri_bank_q <= '0;
      pri_sh_q   <= '0;
      tgt_q      <= '0;
      cfg_bank_q <= '1;
      cfg_sh_q   <= '0;
    end else if (wr) begin
      ctrl_q     <= ctrl_d;
      pri_bank_q <= pri_bank_d;
      pri_sh_q   <= pri_sh_d;
      tgt_q      <= tgt_d;
      cfg_bank_q <= cfg_bank_d;
      cfg_sh_q   <= cfg_sh_d;
    end
  end

  // read path
  logic [31:0] rword, rdata_d;
  always_comb begin
    rword = '0;
    unique case (region)
      RG_CTRL:           rword = {31'd0, ctrl_q};
      RG_TYPE:           rword = TYPE_VALUE;
      RG_IDENT:          rword = IDENT_VALUE;
      RG_SETEN, RG_CLREN: rword = en_rd;
      RG_SETPD, RG_CLRPD: rword = pd_rd;
      RG_PRIO: begin
        for (int l = 0; l < 4; l++) begin
          if (int'(word) * 4 + l < 32) rword[8*l +: 8] = pri_bank_q[req_cpu][5'(int'(word) * 4 + l)];
          else rword[8*l +: 8] = pri_sh_q[SH_W'(int'(word) * 4 + l - 32)];
        end
      end
      RG_TGT: begin
        for (int l = 0; l < 4; l++) begin
          if (int'(word) * 4 + l < 32) rword[8*l +: 8] = 8'b1 << req_cpu;
          else rword[8*l +: 8] = 8'b1 << tgt_q[SH_W'(int'(word) * 4 + l - 32)];
        end
      end
      RG_CFG: begin
        if (word == 8'd0) rword = CFG_LOCKED;
        else begin
          for (int k = 0; k < 16; k++) begin
            if (word == 8'd1) rword[2*k+1] = cfg_bank_q[req_cpu][k];
            else rword[2*k+1] = cfg_sh_q[SH_W'((int'(word) - 2) * 16 + k)];
          end
        end
      end
      default:           rword = '0;
    endcase
    rdata_d = (err || req_write) ? 32'd0 : ((rword >> shift) & len_mask);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_err   <= err;
        rsp_rdata <= rdata_d;
      end
    end
  end

  distr_pendcalc #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_pend (
    .glb_en(ctrl_q), .en_bank(en_bank), .pd_bank(pd_bank),
    .en_sh(en_sh), .pd_sh(pd_sh), .tgt(tgt_q), .pend(irq_pend)
  );

endmodule

// File: rtl/distr_regbank_chk.sv
module distr_regbank_chk
  import distr_pkg::*;
#(
  parameter int  NUM_CPU = 4,
  localparam int CPU_W   = $clog2(NUM_CPU)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [CPU_W-1:0]   req_cpu,
  input logic [11:0]        req_addr,
  input logic [1:0]         req_size,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic [31:0]        rsp_rdata,
  input logic [NUM_CPU-1:0] irq_pend
);
  logic rd_word;
  assign rd_word = req_valid && !req_write && req_size == 2'd2;

  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r3_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == SIZE_DWORD) |=> (rsp_err && rsp_rdata == 32'd0));

  a_r3_err_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == SIZE_DWORD) |=> $stable(irq_pend));

  a_r4_ident: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word && req_addr == 12'h008) |=> rsp_rdata == IDENT_VALUE);

  a_r6_sgi_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word && req_addr == 12'h180) |=> rsp_rdata[15:0] == 16'hFFFF);

  a_r11_priv_target: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word && req_addr[11:5] == 7'b1000000) |=>
      rsp_rdata == {4{8'b1 << $past(req_cpu)}});

endmodule

bind distr_regbank distr_regbank_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .req_valid(req_valid), .req_write(req_write),
  .req_cpu(req_cpu), .req_addr(req_addr), .req_size(req_size),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .irq_pend(irq_pend)
);

// File: tb/distr_regbank_test.sv
module distr_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CPU    = 4;
  localparam int NUM_IRQ    = 128;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_ready;
  logic [1:0]  req_cpu;
  logic [11:0] req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [3:0]  irq_pend;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  distr_regbank #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cpu(req_cpu), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .irq_pend(irq_pend)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic last_valid;

  task automatic access(input logic wr, input int cpu, input logic [11:0] addr,
                        input logic [1:0] sz, input logic [31:0] wd,
                        output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cpu = 2'(cpu);
    req_addr = addr; req_size = sz; req_wdata = wd;
    @(negedge clk);
    rd = rsp_rdata; er = rsp_err; last_valid = rsp_valid;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr32(input int cpu, input logic [11:0] addr, input logic [31:0] d);
    logic [31:0] r; logic e;
    access(1'b1, cpu, addr, 2'd2, d, r, e);
  endtask

  task automatic rd_chk(input string tag, input int cpu, input logic [11:0] addr,
                        input logic [1:0] sz, input logic [31:0] exp);
    logic [31:0] r; logic e;
    access(1'b0, cpu, addr, sz, 32'd0, r, e);
    check(tag, r, exp);
  endtask

  task automatic t_reset;
    check("R1 ready", {31'd0, req_ready}, 32'd1);
    check("R14 reset pend", {28'd0, irq_pend}, 32'd0);
    rd_chk("R4 ctrl reset", 0, 12'h000, 2'd2, 32'd0);
    rd_chk("R4 type", 0, 12'h004, 2'd2, 32'h63);
    rd_chk("R4 ident", 0, 12'h008, 2'd2, 32'h4B00043B);
    rd_chk("R5 enable reset", 2, 12'h100, 2'd2, 32'h0000FFFF);
    rd_chk("R12 cfg private reset", 1, 12'hC04, 2'd2, 32'hAAAAAAAA);
    rd_chk("R12 cfg shared reset", 0, 12'hC08, 2'd2, 32'h0);
  endtask

  task automatic t_bus;
    logic [31:0] r; logic e;
    access(1'b0, 0, 12'h004, 2'd2, 32'd0, r, e);
    check("R1 rsp_valid", {31'd0, last_valid}, 32'd1);
    check("R1 no err", {31'd0, e}, 32'd0);
    @(negedge clk);
    check("R1 idle", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_enable;
    wr32(0, 12'h104, 32'h5);
    rd_chk("R5 set-enable", 0, 12'h104, 2'd2, 32'h5);
    wr32(0, 12'h184, 32'h1);
    rd_chk("R5 clear-enable", 0, 12'h104, 2'd2, 32'h4);
    rd_chk("R5 clear alias read", 0, 12'h184, 2'd2, 32'h4);
    wr32(0, 12'h180, 32'hFFFFFFFF);
    rd_chk("R6 low lines locked", 0, 12'h100, 2'd2, 32'h0000FFFF);
  endtask

  task automatic t_subword;
    logic [31:0] r; logic e;
    access(1'b1, 0, 12'h421, 2'd0, 32'hFFFF_FFA5, r, e);
    rd_chk("R2 R9 byte write", 0, 12'h420, 2'd2, 32'h0000A500);
    rd_chk("R2 byte read", 0, 12'h421, 2'd0, 32'hA5);
    access(1'b1, 0, 12'h422, 2'd1, 32'hFFFF_1234, r, e);
    rd_chk("R2 half write", 0, 12'h420, 2'd2, 32'h1234A500);
    rd_chk("R2 half read", 0, 12'h422, 2'd1, 32'h1234);
  endtask

  task automatic t_bank;
    wr32(0, 12'h400, 32'h11223344);
    rd_chk("R8 R9 own priority", 0, 12'h400, 2'd2, 32'h11223344);
    rd_chk("R8 other cpu priority", 1, 12'h400, 2'd2, 32'h0);
  endtask

  task automatic t_pending;
    wr32(1, 12'h100, 32'h00100000);
    wr32(1, 12'h200, 32'h00100000);
    check("R14 global off", {28'd0, irq_pend}, 32'h0);
    rd_chk("R7 set-pend read", 1, 12'h200, 2'd2, 32'h00100000);
    rd_chk("R8 pend private", 0, 12'h200, 2'd2, 32'h0);
    wr32(0, 12'h000, 32'h1);
    check("R14 private line", {28'd0, irq_pend}, 32'h2);
    wr32(1, 12'h280, 32'h00100000);
    check("R7 R14 clear-pend", {28'd0, irq_pend}, 32'h0);
  endtask

  task automatic t_target;
    logic [31:0] r; logic e;
    wr32(0, 12'h828, 32'hF00C0006);
    rd_chk("R10 target reduce", 0, 12'h828, 2'd2, 32'h01040102);
    wr32(0, 12'h104, 32'h400);
    wr32(0, 12'h204, 32'h400);
    check("R14 shared to cpu2", {28'd0, irq_pend}, 32'h4);
    access(1'b1, 0, 12'h82A, 2'd0, 32'h08, r, e);
    check("R10 R14 retarget", {28'd0, irq_pend}, 32'h8);
    rd_chk("R10 R2 other bytes kept", 0, 12'h828, 2'd2, 32'h01080102);
    wr32(0, 12'h284, 32'h400);
    check("R14 shared cleared", {28'd0, irq_pend}, 32'h0);
  endtask

  task automatic t_priv_target;
    rd_chk("R11 private target", 2, 12'h800, 2'd2, 32'h04040404);
    wr32(2, 12'h804, 32'hFFFFFFFF);
    rd_chk("R11 write ignored", 2, 12'h804, 2'd2, 32'h04040404);
  endtask

  task automatic t_cfg;
    logic [31:0] r; logic e;
    wr32(0, 12'hC00, 32'h0);
    rd_chk("R12 word0 locked", 0, 12'hC00, 2'd2, 32'hAAAAAAAA);
    wr32(0, 12'hC08, 32'hFFFFFFFF);
    rd_chk("R12 odd bits only", 0, 12'hC08, 2'd2, 32'hAAAAAAAA);
    access(1'b1, 0, 12'hC08, 2'd0, 32'h0, r, e);
    rd_chk("R12 R2 byte cfg", 0, 12'hC08, 2'd2, 32'hAAAAAA00);
  endtask

  task automatic t_zero;
    wr32(0, 12'h080, 32'hFFFFFFFF);
    rd_chk("R13 group zero", 0, 12'h080, 2'd2, 32'h0);
    wr32(0, 12'h300, 32'hFFFFFFFF);
    rd_chk("R13 active zero", 0, 12'h300, 2'd2, 32'h0);
    wr32(0, 12'h004, 32'h0);
    rd_chk("R4 type write ignored", 0, 12'h004, 2'd2, 32'h63);
  endtask

  task automatic t_err;
    logic [31:0] r; logic e;
    access(1'b1, 0, 12'h204, 2'd3, 32'h400, r, e);
    check("R3 err flag", {31'd0, e}, 32'd1);
    check("R3 err data", r, 32'd0);
    check("R3 no pend", {28'd0, irq_pend}, 32'h0);
    rd_chk("R3 state kept", 0, 12'h204, 2'd2, 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_cpu = '0;
    req_addr = '0; req_size = 2'd2; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bus();
    t_enable();
    t_subword();
    t_bank();
    t_pending();
    t_target();
    t_priv_target();
    t_cfg();
    t_zero();
    t_err();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule